// File: doc/BRIEF.md
# Pipelined Converter Sub-Code Alignment and Correction

This block sits behind the analog section of a seven-stage pipelined converter. Each stage resolves 2.5 bits, so it gives a 3-bit code from 0 to 6. All seven codes arrive together on one 21-bit bus, but they belong to different samples: a stage reports its part of a sample one conversion beat after the stage in front of it. The block delays every stage code so that the seven codes of one sample meet in the same beat. It then removes the stage redundancy with a shifted add, where each stage's code is added two bit positions below the previous stage's code.

The first two stages are calibrated. For each of them the block looks up a signed correction term, selected by that stage's code, in a table that is driven from outside, and adds it to the sum. The result is clamped to the 15-bit range and presented in offset binary. An over-range flag marks a clamped sample, and a one-cycle data-ready strobe tells the receiver that a new word is on the bus.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, code_out is 0 and ovr_out and rdy_out are low.
- R2: Stage i (i = 1..7) drives precode bits [3*(7-i)+2 : 3*(7-i)], so stage 1 occupies [20:18] and stage 7 occupies [2:0]. A sample's stage-i code is presented i-1 enabled beats after its stage-1 code.
- R3: A sample whose stage-1 code is presented on enabled beat b appears on code_out after the clock edge of enabled beat b+6. rdy_out is high for exactly that one cycle.
- R4: rdy_out stays low during the first six enabled beats after reset.
- R5: The uncorrected value is the sum over i of code_i * 4^(7-i), in offset binary. All codes at 3 give 16383.
- R6: For stages 1 and 2, a signed 8-bit correction term is added to the sum. The term for stage s (s = 0 for stage 1) and code c (0..6) sits at cal_terms[(s*7+c)*8 +: 8].
- R7: If the corrected sum is below 0, code_out becomes 0 and ovr_out becomes 1.
- R8: If the corrected sum is above 32767, code_out becomes 32767 and ovr_out becomes 1.
- R9: In a cycle with stg_en low, no delay line advances. code_out and ovr_out keep their values and rdy_out is low in the following cycle.
- R10: A sample whose corrected sum lies in 0..32767 clears ovr_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stg_en | input | 1 | Marks a conversion beat; the delay lines and the output advance only on a beat |
| precode | input | 21 | Raw stage codes, 3 bits per stage, stage 1 in the top bits |
| cal_terms | input | 112 | Signed correction table: 2 stages x 7 codes x 8 bits |
| code_out | output | 15 | Corrected code in offset binary |
| ovr_out | output | 1 | High when the current code was clamped |
| rdy_out | output | 1 | One-cycle strobe when a new code is presented |

## Verification
Some properties are checked by the assertions on every cycle:
- a strobe follows every enabled beat once the pipeline is full, and only then;
- the outputs hold and the strobe stays low after a cycle without a beat;
- a raised over-range flag always comes with a code pinned to 0 or to full scale.

The rest can only be shown by the bench's scenarios, which compare each output word with a sum recomputed from the per-sample stage codes and the calibration table. That covers the correct deskew of each bus field, the weight given to each stage, the choice of correction entry, the values at which the output saturates, and the clearing of the flag by the next in-range sample.

// File: rtl/adcdc_pkg.sv
package adcdc_pkg;
  localparam int SUB_W = 3;   // bits per 2.5-bit stage code
  localparam int NCODE = 7;   // legal stage codes 0..6

  // Weight of one stage code: two bit positions per stage, last stage at LSB.
  function automatic int stage_term(input logic [SUB_W-1:0] code, input int idx, input int nstg);
    return int'(code) << (2 * (nstg - 1 - idx));
  endfunction

  // Clamp a signed sum into [0, 2^w - 1].
  function automatic int clamp_range(input int acc, input int w);
    int fs;
    fs = (1 << w) - 1;
    if (acc < 0) return 0;
    if (acc > fs) return fs;
    return acc;
  endfunction

  function automatic logic out_of_range(input int acc, input int w);
    return (acc < 0) || (acc > ((1 << w) - 1));
  endfunction
endpackage

// File: rtl/adcdc_align.sv
module adcdc_align #(
  parameter int NSTG  = 7,
  parameter int SUB_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [NSTG*SUB_W-1:0]         pre,
  output logic [NSTG-1:0][SUB_W-1:0]    aligned
);
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int DLY = NSTG - 1 - g;
    localparam int LSB = SUB_W * (NSTG - 1 - g);
    if (DLY == 0) begin : g_pass
      assign aligned[g] = pre[LSB +: SUB_W];
    end else begin : g_dly
      logic [DLY-1:0][SUB_W-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else if (en) begin
          sr[0] <= pre[LSB +: SUB_W];
          for (int j = 1; j < DLY; j++) sr[j] <= sr[j-1];
        end
      end
      assign aligned[g] = sr[DLY-1];
    end
  end
endmodule

// File: rtl/adcdc_correct.sv
module adcdc_correct #(
  parameter int NSTG   = 7,
  parameter int SUB_W  = 3,
  parameter int N_CAL  = 2,
  parameter int CORR_W = 8,
  parameter int OUT_W  = 15,
  localparam int CAL_W = N_CAL * adcdc_pkg::NCODE * CORR_W
) (
  input  logic [NSTG-1:0][SUB_W-1:0] aligned,
  input  logic [CAL_W-1:0]           cal_terms,
  output logic [OUT_W-1:0]           code,
  output logic                       ovr
);
  int acc;
  int sat;

  always_comb begin
    acc = 0;
    for (int idx = 0; idx < NSTG; idx++)
      acc = acc + adcdc_pkg::stage_term(aligned[idx], idx, NSTG);
    for (int s = 0; s < N_CAL; s++) begin
      if (int'(aligned[s]) < adcdc_pkg::NCODE)
        acc = acc + int'($signed(cal_terms[(s*adcdc_pkg::NCODE + int'(aligned[s]))*CORR_W +: CORR_W]));
    end
    sat  = adcdc_pkg::clamp_range(acc, OUT_W);
    ovr  = adcdc_pkg::out_of_range(acc, OUT_W);
    code = sat[OUT_W-1:0];
  end
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NSTG   = 7,
  parameter int N_CAL  = 2,
  parameter int CORR_W = 8,
  localparam int SUB_W = adcdc_pkg::SUB_W,
  localparam int PRE_W = NSTG * SUB_W,
  localparam int OUT_W = 2 * NSTG + 1,
  localparam int CAL_W = N_CAL * adcdc_pkg::NCODE * CORR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_en,
  input  logic [PRE_W-1:0] precode,
  input  logic [CAL_W-1:0] cal_terms,
  output logic [OUT_W-1:0] code_out,
  output logic             ovr_out,
  output logic             rdy_out
);
  localparam int FILL  = NSTG - 1;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [NSTG-1:0][SUB_W-1:0] aligned;
  logic [OUT_W-1:0]           code_nxt;
  logic                       ovr_nxt;
  logic [CNT_W-1:0]           fill_cnt;
  logic                       pipe_full;
  logic                       beat_fire;

  adcdc_align #(.NSTG(NSTG), .SUB_W(SUB_W)) u_align (
    .clk(clk), .rst_n(rst_n), .en(stg_en), .pre(precode), .aligned(aligned)
  );

  adcdc_correct #(.NSTG(NSTG), .SUB_W(SUB_W), .N_CAL(N_CAL), .CORR_W(CORR_W), .OUT_W(OUT_W)) u_corr (
    .aligned(aligned), .cal_terms(cal_terms), .code(code_nxt), .ovr(ovr_nxt)
  );

  assign pipe_full = (fill_cnt == CNT_W'(FILL));
  assign beat_fire = stg_en && pipe_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      code_out <= '0;
      ovr_out  <= 1'b0;
      rdy_out  <= 1'b0;
    end else begin
      rdy_out <= beat_fire;
      if (stg_en && !pipe_full) fill_cnt <= fill_cnt + 1'b1;
      if (beat_fire) begin
        code_out <= code_nxt;
        ovr_out  <= ovr_nxt;
      end
    end
  end
endmodule

// File: rtl/pipe_adc_corrector_chk.sv
module pipe_adc_corrector_chk #(
  parameter int NSTG  = 7,
  parameter int OUT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stg_en,
  input logic [OUT_W-1:0] code_out,
  input logic             ovr_out,
  input logic             rdy_out
);
  localparam int SEEN_W = $clog2(NSTG + 1);
  logic [SEEN_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (stg_en && seen < SEEN_W'(NSTG)) seen <= seen + 1'b1;
  end

  // R4: no strobe before the pipeline has taken enough beats
  a_r4_no_early_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_out |-> (seen >= SEEN_W'(NSTG)));

  // R3: strobe only in the cycle after a beat
  a_r3_rdy_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_out |-> $past(stg_en));

  // R3: every beat with a full pipeline yields a strobe
  a_r3_full_beat_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_en && seen >= SEEN_W'(NSTG - 1)) |=> rdy_out);

  // R9: outputs hold when no beat
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_en |=> ($stable(code_out) && $stable(ovr_out) && !rdy_out));

  // R7 and R8: flagged codes sit at a rail
  a_r8_flag_at_rail: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_out |-> (code_out == '0 || code_out == '1));
endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(.NSTG(NSTG), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stg_en(stg_en),
  .code_out(code_out), .ovr_out(ovr_out), .rdy_out(rdy_out)
);

// File: tb/pipe_adc_corrector_bench.sv
`timescale 1ns/1ps
module pipe_adc_corrector_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stg_en = 1'b0;
  logic [20:0]  precode = '0;
  logic [111:0] cal_terms = '0;
  logic [14:0]  code_out;
  logic         ovr_out;
  logic         rdy_out;

  int checks = 0;
  int errors = 0;
  int smp [0:47][0:6];
  int cal [0:1][0:6];

  always #2 clk = ~clk;

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk(clk), .rst_n(rst_n), .stg_en(stg_en), .precode(precode),
    .cal_terms(cal_terms), .code_out(code_out), .ovr_out(ovr_out), .rdy_out(rdy_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_sum(input int n);
    int acc = 0;
    for (int i = 0; i < 7; i++) acc += smp[n][i] * (4 ** (6 - i));
    for (int s = 0; s < 2; s++) if (smp[n][s] <= 6) acc += cal[s][smp[n][s]];
    return acc;
  endfunction

  task automatic load_cal();
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 7; c++)
        cal_terms[(s*7+c)*8 +: 8] = cal[s][c][7:0];
  endtask

  task automatic clear_cal();
    for (int s = 0; s < 2; s++) for (int c = 0; c < 7; c++) cal[s][c] = 0;
    load_cal();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stg_en = 1'b0; precode = '0;
    repeat (2) @(negedge clk);
    chk(code_out == 0 && !ovr_out && !rdy_out, "R1 in reset", int'(code_out), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(code_out == 0 && !ovr_out && !rdy_out, "R1 after reset", int'(code_out), 0);
  endtask

  // Drive ns samples skewed per stage; optionally insert idle gaps.
  task automatic run_stream(input int ns, input int gap, input string tag);
    do_reset();
    for (int b = 0; b < ns + 6; b++) begin
      @(negedge clk);
      stg_en = 1'b1;
      for (int i = 0; i < 7; i++) begin
        int s = b - i;
        precode[3*(6-i) +: 3] = (s >= 0 && s < ns) ? smp[s][i][2:0] : 3'd0;
      end
      @(posedge clk); #1;
      if (b < 6) begin
        chk(!rdy_out, "R4 early beat", int'(rdy_out), 0);
      end else begin
        int acc = model_sum(b - 6);
        int ex = (acc < 0) ? 0 : (acc > 32767 ? 32767 : acc);
        bit eo = (acc < 0) || (acc > 32767);
        chk(rdy_out, {tag, " R3 strobe"}, int'(rdy_out), 1);
        chk(int'(code_out) == ex, {tag, " R2 R3 code"}, int'(code_out), ex);
        chk(ovr_out == eo, {tag, " ovr"}, int'(ovr_out), int'(eo));
      end
      if (gap > 0 && (b % gap) == gap - 1) begin
        logic [14:0] held_c = code_out;
        logic        held_o = ovr_out;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          stg_en = 1'b0;
          precode = 21'h15A5A5 ^ 21'(k);
          @(posedge clk); #1;
          chk(code_out == held_c && ovr_out == held_o, "R9 hold", int'(code_out), int'(held_c));
          chk(!rdy_out, "R9 no strobe", int'(rdy_out), 0);
        end
      end
    end
    @(negedge clk);
    stg_en = 1'b0;
  endtask

  task automatic t_plain();
    clear_cal();
    for (int n = 0; n < 20; n++) for (int i = 0; i < 7; i++) smp[n][i] = (n * 5 + i * 3) % 7;
    for (int i = 0; i < 7; i++) smp[0][i] = 3;
    run_stream(20, 0, "R5 plain");
    // R5: literal midscale check, sample 0 appears on beat 6
    do_reset();
    for (int b = 0; b < 7; b++) begin
      @(negedge clk); stg_en = 1'b1;
      precode = {7{3'd3}};
      @(posedge clk); #1;
    end
    chk(int'(code_out) == 16383, "R5 midscale", int'(code_out), 16383);
    @(negedge clk); stg_en = 1'b0;
  endtask

  task automatic t_cal();
    for (int c = 0; c < 7; c++) begin cal[0][c] = c * 7 - 20; cal[1][c] = -c * 3; end
    load_cal();
    for (int n = 0; n < 16; n++) for (int i = 0; i < 7; i++) smp[n][i] = (n * 3 + i * 2 + 1) % 7;
    run_stream(16, 0, "R6 cal");
  endtask

  task automatic t_low();
    clear_cal();
    cal[0][0] = -50; load_cal();
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < 7; i++) smp[n][i] = (n % 2 == 0) ? 0 : ((i == 0) ? 0 : 3);
    run_stream(8, 0, "R7 R10 low");
  endtask

  task automatic t_high();
    clear_cal();
    cal[0][6] = 5; load_cal();
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < 7; i++) smp[n][i] = (n % 2 == 0) ? 6 : 2;
    run_stream(8, 0, "R8 R10 high");
  endtask

  task automatic t_gap();
    clear_cal();
    for (int n = 0; n < 14; n++) for (int i = 0; i < 7; i++) smp[n][i] = (n + i * 4) % 7;
    run_stream(14, 3, "R9 gap");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_plain();
    t_cal();
    t_low();
    t_high();
    t_gap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule